// File: doc/BRIEF.md
# DDR bank command timing enforcer

This block watches the command stream aimed at one DDR SDRAM bank and decides, cycle by cycle, whether the command being requested may go out. It accepts a request made of a command type, a bank select and an auto-precharge flag. It raises a grant only when the bank is in a state that accepts that command and every timing interval measured from earlier commands has elapsed. A request that cannot go out yet stays pending with the grant low. It is never discarded, and it is granted in the first cycle that satisfies all rules.

The row-active minimum (tRAS), row cycle (tRC) and precharge period (tRP) are given in clock cycles on configuration inputs. A burst-length select sets where a READ with auto-precharge closes the row. That closing point is half the burst length after the READ, but never before tRAS has elapsed since the ACTIVE. The block marks the closing point with a one-cycle internal precharge event. It also reports the bank as idle, active or precharging.

The controller in the state machine has four states: IDLE (row closed), OPEN (row active), APWAIT (auto-precharge pending, reported as active) and PRECH (precharging). The named transitions are:
- IDLE to OPEN on a granted ACTIVE.
- OPEN to APWAIT on a granted READ with auto-precharge.
- OPEN to PRECH on a granted PRECHARGE, or directly to IDLE when tRP is at most one.
- APWAIT to PRECH on the internal precharge event, or directly to IDLE when tRP is at most one.
- PRECH to IDLE when the precharge period ends.

Top module: `ddr_bank_gate`

## Requirements
- R1: After reset the bank reports IDLE, the internal precharge event is low, and the grant is low while no request is valid.
- R2: The command codes are 00 ACTIVE, 01 READ, 10 PRECHARGE and 11 PRECHARGE-all. The bank state codes are 00 IDLE, 01 ACTIVE and 10 PRECHARGING, and code 11 never appears. An ACTIVE is granted only while IDLE, and the bank reports ACTIVE in the cycle after it.
- R3: Two granted ACTIVEs are at least max(tRC,1) clock edges apart.
- R4: After a precharge starts at edge k, the bank reports PRECHARGING until edge k+tRP-1 and IDLE from that edge on. The next ACTIVE is granted no earlier than edge k+max(tRP,1).
- R5: A PRECHARGE to an active row is granted no earlier than tRAS edges after the ACTIVE.
- R6: A READ is granted only while the row is ACTIVE. A READ without auto-precharge leaves the bank ACTIVE. A READ while IDLE or PRECHARGING is held with grant low.
- R7: After a READ with auto-precharge granted at edge r, with the ACTIVE at edge a, the internal precharge event pulses for exactly one cycle at edge max(r+BL/2, a+tRAS). BL is 4 when the burst select is 0 and 8 when it is 1. The precharge period starts at that edge.
- R8: While an auto-precharge is pending, READ and PRECHARGE requests to the bank are held and the bank reports ACTIVE.
- R9: A PRECHARGE to a bank that is IDLE or PRECHARGING is granted at once and changes neither the state nor the time at which the next ACTIVE can be granted.
- R10: A PRECHARGE-all is handled as a PRECHARGE to this bank whatever the bank select holds.
- R11: A request whose bank select differs from the tracked bank, other than PRECHARGE-all, is granted at once and has no effect on this bank.
- R12: A request that is held is granted in the first cycle in which all rules are met, and not later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A command request is present |
| req_cmd | input | 2 | Command code (R2) |
| req_bank | input | BANK_W | Bank select of the request |
| req_ap | input | 1 | Auto-precharge flag for READ |
| cfg_bl8 | input | 1 | Burst select: 0 = BL4, 1 = BL8 |
| cfg_tras | input | TW | Row-active minimum in cycles |
| cfg_trc | input | TW | Row cycle time in cycles |
| cfg_trp | input | TW | Precharge period in cycles |
| req_grant | output | 1 | The request goes out at this clock edge |
| ap_event | output | 1 | Internal auto-precharge starts at this edge |
| bank_state | output | 2 | 00 IDLE, 01 ACTIVE, 10 PRECHARGING |

## Verification
Two things can happen in the same cycle. The auto-precharge event can release a PRECHARGE request that was held through the pending phase. The BL/2 count and the tRAS count can also run out together, so either one may set when the row closes. The bench sweeps tRAS, tRC, tRP and burst length so that each of these orderings occurs, including exact ties. It queues a PRECHARGE right behind every READ with auto-precharge. It then checks that the event edge is the larger of the two deadlines, and that the held PRECHARGE is granted on the following edge as a no-op that does not move the next ACTIVE.

// File: rtl/ddr_bank_pkg.sv
`timescale 1ns/1ps
package ddr_bank_pkg;
    typedef enum logic [1:0] {
        CMD_ACT    = 2'b00,
        CMD_RD     = 2'b01,
        CMD_PRE    = 2'b10,
        CMD_PREALL = 2'b11
    } cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_OPEN   = 2'd1,
        ST_APWAIT = 2'd2,
        ST_PRECH  = 2'd3
    } fsm_e;

    localparam logic [1:0] BS_IDLE    = 2'b00;
    localparam logic [1:0] BS_ACTIVE  = 2'b01;
    localparam logic [1:0] BS_PRECHG  = 2'b10;

    localparam int NUM_TIMERS = 4;
    localparam int IX_RAS = 0;
    localparam int IX_RC  = 1;
    localparam int IX_RP  = 2;
    localparam int IX_AP  = 3;
endpackage

// File: rtl/ddr_tdown.sv
`timescale 1ns/1ps
module ddr_tdown #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] ld_val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= ld_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/ddr_bank_rules.sv
`timescale 1ns/1ps
module ddr_bank_rules
    import ddr_bank_pkg::*;
(
    input  fsm_e state,
    input  cmd_e cmd,
    input  logic hit,
    input  logic ras_done,
    input  logic rc_done,
    output logic ok
);
    always_comb begin
        ok = 1'b0;
        if (!hit) begin
            ok = 1'b1;
        end else begin
            unique case (cmd)
                CMD_ACT: ok = (state == ST_IDLE) && rc_done;
                CMD_RD:  ok = (state == ST_OPEN);
                CMD_PRE, CMD_PREALL: begin
                    unique case (state)
                        ST_OPEN:   ok = ras_done;
                        ST_APWAIT: ok = 1'b0;
                        ST_IDLE,
                        ST_PRECH:  ok = 1'b1;
                        default:   ok = 1'b0;
                    endcase
                end
                default: ok = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/ddr_bank_gate.sv
`timescale 1ns/1ps
module ddr_bank_gate
    import ddr_bank_pkg::*;
#(
    parameter int TW      = 6,
    parameter int BANK_W  = 2,
    parameter int BANK_ID = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_cmd,
    input  logic [BANK_W-1:0] req_bank,
    input  logic              req_ap,
    input  logic              cfg_bl8,
    input  logic [TW-1:0]     cfg_tras,
    input  logic [TW-1:0]     cfg_trc,
    input  logic [TW-1:0]     cfg_trp,
    output logic              req_grant,
    output logic              ap_event,
    output logic [1:0]        bank_state
);
    localparam logic [BANK_W-1:0] MY_BANK = BANK_ID[BANK_W-1:0];
    localparam logic [TW-1:0]     ONE     = TW'(1);
    localparam logic [TW-1:0]     TWO     = TW'(2);
    localparam logic [TW-1:0]     AP_BL4  = TW'(1);
    localparam logic [TW-1:0]     AP_BL8  = TW'(3);

    fsm_e state_q, state_d;
    cmd_e cmd;
    logic hit, ok, fire;
    logic act_go, rdap_go, pre_go, ap_go, trp_short;

    logic [NUM_TIMERS-1:0]         t_load;
    logic [NUM_TIMERS-1:0]         t_zero;
    logic [NUM_TIMERS-1:0][TW-1:0] t_ld;

    assign cmd  = cmd_e'(req_cmd);
    assign hit  = (req_bank == MY_BANK) || (cmd == CMD_PREALL);
    assign fire = req_valid && ok && hit;

    assign act_go  = fire && (cmd == CMD_ACT);
    assign rdap_go = fire && (cmd == CMD_RD) && req_ap;
    assign pre_go  = fire && ((cmd == CMD_PRE) || (cmd == CMD_PREALL))
                     && (state_q == ST_OPEN);
    assign ap_go   = (state_q == ST_APWAIT) && t_zero[IX_AP] && t_zero[IX_RAS];
    assign trp_short = (cfg_trp <= ONE);

    // load values: one less than the interval, precharge two less (state exit)
    assign t_ld[IX_RAS] = (cfg_tras > ONE) ? cfg_tras - ONE : '0;
    assign t_ld[IX_RC]  = (cfg_trc  > ONE) ? cfg_trc  - ONE : '0;
    assign t_ld[IX_RP]  = (cfg_trp  > TWO) ? cfg_trp  - TWO : '0;
    assign t_ld[IX_AP]  = cfg_bl8 ? AP_BL8 : AP_BL4;

    assign t_load[IX_RAS] = act_go;
    assign t_load[IX_RC]  = act_go;
    assign t_load[IX_RP]  = pre_go || ap_go;
    assign t_load[IX_AP]  = rdap_go;

    for (genvar gi = 0; gi < NUM_TIMERS; gi++) begin : g_timer
        ddr_tdown #(.W(TW)) timer_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .load   (t_load[gi]),
            .ld_val (t_ld[gi]),
            .zero   (t_zero[gi])
        );
    end

    ddr_bank_rules rules_i (
        .state    (state_q),
        .cmd      (cmd),
        .hit      (hit),
        .ras_done (t_zero[IX_RAS]),
        .rc_done  (t_zero[IX_RC]),
        .ok       (ok)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (act_go) state_d = ST_OPEN;
            ST_OPEN: begin
                if (rdap_go)     state_d = ST_APWAIT;
                else if (pre_go) state_d = trp_short ? ST_IDLE : ST_PRECH;
            end
            ST_APWAIT: if (ap_go) state_d = trp_short ? ST_IDLE : ST_PRECH;
            ST_PRECH:  if (t_zero[IX_RP]) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        req_grant = req_valid && ok;
        ap_event  = ap_go;
        unique case (state_q)
            ST_IDLE:             bank_state = BS_IDLE;
            ST_OPEN, ST_APWAIT:  bank_state = BS_ACTIVE;
            ST_PRECH:            bank_state = BS_PRECHG;
            default:             bank_state = BS_IDLE;
        endcase
    end
endmodule

// File: rtl/ddr_bank_gate_chk.sv
`timescale 1ns/1ps
module ddr_bank_gate_chk
    import ddr_bank_pkg::*;
#(
    parameter int TW      = 6,
    parameter int BANK_W  = 2,
    parameter int BANK_ID = 0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [1:0]        req_cmd,
    input logic [BANK_W-1:0] req_bank,
    input logic              req_ap,
    input logic              cfg_bl8,
    input logic [TW-1:0]     cfg_tras,
    input logic [TW-1:0]     cfg_trc,
    input logic [TW-1:0]     cfg_trp,
    input logic              req_grant,
    input logic              ap_event,
    input logic [1:0]        bank_state
);
    localparam int SW = TW + 1;
    localparam logic [SW-1:0] SMAX = '1;

    logic ours, act_g, rd_g, rdap_g, pre_start;
    logic [SW-1:0] since_act, since_pre, since_rdap;
    logic seen_act, seen_pre;
    logic [SW-1:0] trc_eff, trp_eff, half_bl;

    assign ours   = req_valid && req_grant &&
                    ((req_bank == BANK_ID[BANK_W-1:0]) || (req_cmd == CMD_PREALL));
    assign act_g  = ours && (req_cmd == CMD_ACT);
    assign rd_g   = ours && (req_cmd == CMD_RD);
    assign rdap_g = rd_g && req_ap;
    assign pre_start = ap_event ||
                       (ours && req_cmd[1] && (bank_state == BS_ACTIVE));
    assign trc_eff = (cfg_trc == '0) ? SW'(1) : SW'(cfg_trc);
    assign trp_eff = (cfg_trp == '0) ? SW'(1) : SW'(cfg_trp);
    assign half_bl = cfg_bl8 ? SW'(4) : SW'(2);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_act  <= '0;
            since_pre  <= '0;
            since_rdap <= '0;
            seen_act   <= 1'b0;
            seen_pre   <= 1'b0;
        end else begin
            if (act_g) begin
                since_act <= SW'(1);
                seen_act  <= 1'b1;
            end else if (since_act != SMAX) begin
                since_act <= since_act + 1'b1;
            end
            if (pre_start) begin
                since_pre <= SW'(1);
                seen_pre  <= 1'b1;
            end else if (since_pre != SMAX) begin
                since_pre <= since_pre + 1'b1;
            end
            if (rdap_g)                   since_rdap <= SW'(1);
            else if (since_rdap != SMAX)  since_rdap <= since_rdap + 1'b1;
        end
    end

    assert_state_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bank_state != 2'b11);
    assert_act_from_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        act_g |-> bank_state == BS_IDLE);
    assert_trc_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (act_g && seen_act) |-> since_act >= trc_eff);
    assert_trp_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (act_g && seen_pre) |-> since_pre >= trp_eff);
    assert_tras_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_start && seen_act) |-> since_act >= SW'(cfg_tras));
    assert_read_open_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_g |-> bank_state == BS_ACTIVE);
    assert_ap_delay_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ap_event |-> since_rdap >= half_bl);
    assert_ap_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ap_event |=> !ap_event);
endmodule

bind ddr_bank_gate ddr_bank_gate_chk #(
    .TW(TW), .BANK_W(BANK_W), .BANK_ID(BANK_ID)
) chk_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
    .req_bank(req_bank), .req_ap(req_ap), .cfg_bl8(cfg_bl8),
    .cfg_tras(cfg_tras), .cfg_trc(cfg_trc), .cfg_trp(cfg_trp),
    .req_grant(req_grant), .ap_event(ap_event), .bank_state(bank_state)
);

// File: tb/ddr_bank_gate_tb_top.sv
`timescale 1ns/1ps
module ddr_bank_gate_tb_top;
    localparam int TW = 6;
    localparam int BW = 2;
    localparam logic [1:0] C_ACT = 2'b00, C_RD = 2'b01, C_PRE = 2'b10, C_PALL = 2'b11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [1:0] req_cmd = 2'b00;
    logic [BW-1:0] req_bank = '0;
    logic req_ap = 1'b0;
    logic cfg_bl8 = 1'b0;
    logic [TW-1:0] cfg_tras = TW'(1), cfg_trc = TW'(1), cfg_trp = TW'(1);
    logic req_grant, ap_event;
    logic [1:0] bank_state;

    int edge_n = 0, ap_edge = -1, ap_pulses = 0;
    int errs = 0, checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ddr_bank_gate #(.TW(TW), .BANK_W(BW), .BANK_ID(0)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
        .req_bank(req_bank), .req_ap(req_ap), .cfg_bl8(cfg_bl8),
        .cfg_tras(cfg_tras), .cfg_trc(cfg_trc), .cfg_trp(cfg_trp),
        .req_grant(req_grant), .ap_event(ap_event), .bank_state(bank_state)
    );

    always @(posedge clk) begin
        if (ap_event) begin
            ap_edge   <= edge_n + 1;
            ap_pulses <= ap_pulses + 1;
        end
        edge_n <= edge_n + 1;
    end

    function automatic int mx(int a, int b);
        return (a > b) ? a : b;
    endfunction

    task automatic chk(input bit good, input string req, input int act, input int exp);
        checks++;
        if (!good) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    // present a request, wait for grant; ge = edge at which it went out
    task automatic issue(input logic [1:0] c, input logic [BW-1:0] b, input logic ap,
                         output int ge, output int w);
        @(negedge clk);
        req_valid = 1'b1; req_cmd = c; req_bank = b; req_ap = ap;
        w = 0;
        #1;
        while (!req_grant && w < 64) begin
            @(negedge clk); #1; w++;
        end
        if (!req_grant) chk(1'b0, "R12 grant never came", w, 0);
        ge = edge_n + 1;
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errs++; checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        int ga, gr, gp, ga2, grap, gp2, ga3, gp3, w, a_exp, half, p0, e;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(bank_state == 2'b00, "R1 state", bank_state, 0);
        chk(req_grant == 1'b0, "R1 grant", req_grant, 0);
        chk(ap_event == 1'b0, "R1 ap_event", ap_event, 0);

        for (int ras = 1; ras <= 4; ras++)
        for (int rc = 1; rc <= 6; rc++)
        for (int rp = 1; rp <= 3; rp++)
        for (int bl = 0; bl <= 1; bl++) begin
            cfg_tras = TW'(ras); cfg_trc = TW'(rc); cfg_trp = TW'(rp);
            cfg_bl8 = bl[0];
            half = bl ? 4 : 2;
            repeat (20) @(posedge clk);
            issue(C_ACT, 0, 0, ga, w);
            chk(w == 0, "R2 act wait", w, 0);
            chk(bank_state == 2'b01, "R2 state", bank_state, 1);
            issue(C_RD, 0, 0, gr, w);
            chk(gr == ga + 1, "R6 read edge", gr, ga + 1);
            chk(bank_state == 2'b01, "R6 state", bank_state, 1);
            issue(C_PRE, 0, 0, gp, w);
            e = mx(gr + 1, ga + ras);
            chk(gp == e, "R5 pre edge", gp, e);
            chk(bank_state == ((rp > 1) ? 2'b10 : 2'b00), "R4 state", bank_state, (rp > 1) ? 2 : 0);
            issue(C_ACT, 0, 0, ga2, w);
            e = mx(gp + rp, ga + rc);
            chk(ga2 == e, "R3 act edge", ga2, e);
            issue(C_RD, 0, 1, grap, w);
            chk(grap == ga2 + 1, "R7 read-ap edge", grap, ga2 + 1);
            p0 = ap_pulses;
            a_exp = mx(grap + half, ga2 + ras);
            issue(C_PRE, 0, 0, gp2, w);
            chk(gp2 == a_exp + 1, "R8 held pre edge", gp2, a_exp + 1);
            chk(ap_edge == a_exp, "R7 ap edge", ap_edge, a_exp);
            chk(ap_pulses == p0 + 1, "R7 ap pulses", ap_pulses, p0 + 1);
            chk(bank_state == ((rp > 2) ? 2'b10 : 2'b00), "R4 state after ap", bank_state, (rp > 2) ? 2 : 0);
            issue(C_ACT, 0, 0, ga3, w);
            e = mx(mx(a_exp + rp, ga2 + rc), gp2 + 1);
            chk(ga3 == e, "R9 act after no-op pre", ga3, e);
            issue(C_PRE, 0, 0, gp3, w);
            e = mx(ga3 + ras, ga3 + 1);
            chk(gp3 == e, "R12 first legal edge", gp3, e);
        end

        cfg_tras = TW'(3); cfg_trc = TW'(5); cfg_trp = TW'(2); cfg_bl8 = 1'b0;
        repeat (20) @(posedge clk);
        issue(C_ACT, 2, 0, ga, w);
        chk(w == 0, "R11 other bank act", w, 0);
        chk(bank_state == 2'b00, "R11 state", bank_state, 0);
        issue(C_RD, 1, 0, gr, w);
        chk(w == 0, "R11 other bank read", w, 0);
        chk(bank_state == 2'b00, "R11 state read", bank_state, 0);

        @(negedge clk);
        req_valid = 1'b1; req_cmd = C_RD; req_bank = 0; req_ap = 1'b0;
        for (int i = 0; i < 6; i++) begin
            #1 chk(req_grant == 1'b0, "R6 read held in idle", req_grant, 0);
            @(negedge clk);
        end
        req_valid = 1'b0;
        #1 chk(bank_state == 2'b00, "R6 idle kept", bank_state, 0);

        issue(C_PRE, 0, 0, gp, w);
        chk(w == 0, "R9 pre in idle", w, 0);
        chk(bank_state == 2'b00, "R9 idle kept", bank_state, 0);
        issue(C_ACT, 0, 0, ga, w);
        chk(w == 0, "R9 act right after no-op pre", w, 0);
        issue(C_PALL, 3, 0, gp, w);
        chk(gp == ga + 3, "R10 pre-all edge", gp, ga + 3);
        chk(bank_state == 2'b10, "R10 precharging", bank_state, 2);

        repeat (5) @(posedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule